// File: doc/BRIEF.md
# Address Table Slot Search Engine

This block chooses where a new entry goes in a forwarding address table. A one-cycle start pulse carries the request: a 48-bit MAC address, a 12-bit VLAN tag, a flag that says whether the tag takes part in the comparison, and a mode bit that selects a VLAN-only search. The engine reads the table through a read port, one entry per cycle, from index 0 to the last index. While it reads, it records the lowest index in each of three candidate classes: an existing entry that matches the request, an empty slot, and an entry that may be evicted because it was learned dynamically.

When the pass ends, the engine raises `done_o` for one cycle. It reports the best candidate: a match wins, then an empty slot, then an evictable entry. If none exists, it raises the out-of-space flag. The caller writes the entry itself; this engine only selects the index. Each search takes a fixed number of cycles, set by the table depth plus the read latency of the table.

Top module: `ale_srch_engine`

## Requirements
- R1: During and right after reset, `busy_o`, `done_o` and `tbl_rd_en_o` are 0.
- R2: A start pulse taken while idle makes the engine read indices 0, 1, ... DEPTH-1, one per cycle and in ascending order, beginning in the cycle after the start edge. `done_o` is high for exactly one cycle. It rises DEPTH+RD_LAT clock edges after the edge that sampled the start. `busy_o` is low in the done cycle.
- R3: The entry word is laid out as kind[63:62], type[61:60], vlan[59:48], mac[47:0]. In address mode, an entry matches when all of the following hold: its type is 1 or 3, its vlan field equals the compared tag, and all six MAC octets are equal. A match reports tier code 0 (`tier_o`) at the lowest matching index.
- R4: In address mode with `use_vid_i` low, the compared tag is zero, whatever `vid_i` holds.
- R5: With no match, the lowest index whose type is 0 is reported with tier code 1. That index is below DEPTH.
- R6: With neither a match nor a free slot, the engine reports the lowest evictable index with tier code 2. An entry is evictable when all of the following hold: its type is 1 or 3, its multicast bit (mac bit 40) is clear, and its kind is 1 or 3. Kinds 0 and 2 are never evicted.
- R7: When no candidate of any tier exists, `full_o` is 1 and `tier_o` is 3. Otherwise `full_o` is 0.
- R8: With `vlan_only_i` high, only type-2 entries whose vlan field equals `vid_i` match; address entries never match.
- R9: The tiers rank as match over free over evictable, whatever their indices. Within a tier, the lowest index wins.
- R10: A start pulse, or a change of request inputs, while busy has no effect on the scan, its timing or its result, and produces no extra done pulse.
- R11: `idx_o`, `tier_o` and `full_o` stay constant from the done cycle until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request pulse, taken only while idle |
| vlan_only_i | input | 1 | 1: VLAN-only search, 0: address search |
| mac_i | input | 48 | Requested MAC address |
| vid_i | input | 12 | Requested VLAN tag |
| use_vid_i | input | 1 | Compare the tag in address mode (else compare zero) |
| busy_o | output | 1 | Scan in progress |
| tbl_rd_en_o | output | 1 | Table read strobe |
| tbl_rd_idx_o | output | IDX_W | Table read index |
| tbl_rd_data_i | input | ENTRY_W | Table entry, RD_LAT cycles after the strobe |
| done_o | output | 1 | One-cycle completion pulse |
| tier_o | output | 2 | 0 match, 1 free, 2 evictable, 3 none |
| idx_o | output | IDX_W | Selected index (meaningful when full_o is 0) |
| full_o | output | 1 | No index available |

## Verification
The checks assume that the table returns the entry for each strobed index exactly RD_LAT cycles later and that its contents stay fixed during a scan. The bench models the table as a memory with one registered read stage, and it changes table contents only between searches. The checks also assume that start is a single-cycle pulse. The bench drives it for exactly one cycle. It sends the only deliberate overlap, a second pulse carrying different request values, into the middle of a running scan, to show that the second request is ignored.

// File: rtl/ale_srch_pkg.sv
package ale_srch_pkg;
   // Entry word layout (packed, MSB first)
   localparam int unsigned MAC_W      = 48;
   localparam int unsigned VID_W      = 12;
   localparam int unsigned ENTRY_BITS = 64;
   localparam int unsigned MCAST_BIT  = 40;

   // Entry type codes
   localparam logic [1:0] ET_FREE  = 2'd0;
   localparam logic [1:0] ET_ADDR  = 2'd1;
   localparam logic [1:0] ET_VLAN  = 2'd2;
   localparam logic [1:0] ET_VADDR = 2'd3;

   // Learned-address kinds
   localparam logic [1:0] K_PERSIST   = 2'd0;
   localparam logic [1:0] K_UNTOUCHED = 2'd1;
   localparam logic [1:0] K_OUI       = 2'd2;
   localparam logic [1:0] K_TOUCHED   = 2'd3;

   // Candidate tiers, in priority order
   localparam int unsigned NUM_TIERS = 3;
   localparam int unsigned T_MATCH   = 0;
   localparam int unsigned T_FREE    = 1;
   localparam int unsigned T_AGE     = 2;
   localparam logic [1:0]  TIER_NONE = 2'd3;

   typedef struct packed {
      logic [1:0]       kind;
      logic [1:0]       etype;
      logic [VID_W-1:0] vid;
      logic [MAC_W-1:0] mac;
   } entry_t;
endpackage

// File: rtl/ale_srch_classify.sv
module ale_srch_classify
   import ale_srch_pkg::*;
#(
   parameter int unsigned ENTRY_W = 64
) (
   input  logic [ENTRY_W-1:0]   entry_i,
   input  logic                 vlan_only_i,
   input  logic [MAC_W-1:0]     mac_i,
   input  logic [VID_W-1:0]     vid_i,
   input  logic                 use_vid_i,
   output logic [NUM_TIERS-1:0] hit_o
);
   localparam int unsigned OCTETS = MAC_W / 8;

   entry_t            ent;
   logic [OCTETS-1:0] oct_eq;
   logic [VID_W-1:0]  cmp_vid;
   logic              is_addr;
   logic              addr_match;
   logic              vlan_match;
   logic              dyn_kind;

   assign ent = entry_t'(entry_i[ENTRY_BITS-1:0]);

   for (genvar o = 0; o < OCTETS; o++) begin : g_oct
      assign oct_eq[o] = (ent.mac[o*8 +: 8] == mac_i[o*8 +: 8]);
   end

   assign is_addr    = (ent.etype == ET_ADDR) || (ent.etype == ET_VADDR);
   assign cmp_vid    = use_vid_i ? vid_i : '0;
   assign addr_match = is_addr && (ent.vid == cmp_vid) && (&oct_eq);
   assign vlan_match = (ent.etype == ET_VLAN) && (ent.vid == vid_i);
   assign dyn_kind   = (ent.kind == K_UNTOUCHED) || (ent.kind == K_TOUCHED);

   assign hit_o[T_MATCH] = vlan_only_i ? vlan_match : addr_match;
   assign hit_o[T_FREE]  = (ent.etype == ET_FREE);
   assign hit_o[T_AGE]   = is_addr && !ent.mac[MCAST_BIT] && dyn_kind;
endmodule

// File: rtl/ale_srch_first.sv
module ale_srch_first #(
   parameter int unsigned IDX_W = 4
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clear_i,
   input  logic             valid_i,
   input  logic             hit_i,
   input  logic [IDX_W-1:0] idx_i,
   output logic             found_o,
   output logic [IDX_W-1:0] idx_o
);
   logic             found_q;
   logic [IDX_W-1:0] idx_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         found_q <= 1'b0;
         idx_q   <= '0;
      end else if (clear_i) begin
         found_q <= 1'b0;
         idx_q   <= '0;
      end else if (valid_i && hit_i && !found_q) begin
         found_q <= 1'b1;
         idx_q   <= idx_i;
      end
   end

   assign found_o = found_q;
   assign idx_o   = idx_q;
endmodule

// File: rtl/ale_srch_seq.sv
module ale_srch_seq #(
   parameter int unsigned DEPTH  = 16,
   parameter int unsigned RD_LAT = 1,
   parameter int unsigned IDX_W  = 4
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   output logic             busy_o,
   output logic             accept_o,
   output logic             rd_en_o,
   output logic [IDX_W-1:0] rd_idx_o,
   output logic             ret_valid_o,
   output logic [IDX_W-1:0] ret_idx_o,
   output logic             ret_last_o,
   output logic             done_o
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

   typedef enum logic [1:0] {S_IDLE, S_SCAN, S_DRAIN} st_e;

   st_e              st_q, st_d;
   logic [IDX_W-1:0] cnt_q, cnt_d;
   logic             done_q;
   logic             issue_last;
   logic             ret_end;

   assign rd_en_o    = (st_q == S_SCAN);
   assign rd_idx_o   = cnt_q;
   assign issue_last = rd_en_o && (cnt_q == LAST_IDX);
   assign ret_end    = ret_valid_o && ret_last_o;
   assign busy_o     = (st_q != S_IDLE);
   assign done_o     = done_q;

   always_comb begin
      st_d     = st_q;
      cnt_d    = cnt_q;
      accept_o = 1'b0;
      case (st_q)
         S_IDLE: begin
            if (start_i) begin
               accept_o = 1'b1;
               st_d     = S_SCAN;
               cnt_d    = '0;
            end
         end
         S_SCAN: begin
            cnt_d = cnt_q + 1'b1;
            if (issue_last) begin
               cnt_d = '0;
               st_d  = ret_end ? S_IDLE : S_DRAIN;
            end
         end
         S_DRAIN: begin
            if (ret_end) st_d = S_IDLE;
         end
         default: st_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q   <= S_IDLE;
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         cnt_q  <= cnt_d;
         done_q <= ret_end;
      end
   end

   // Return path: align the index with the table's read latency
   if (RD_LAT == 0) begin : g_comb_rd
      assign ret_valid_o = rd_en_o;
      assign ret_idx_o   = rd_idx_o;
      assign ret_last_o  = issue_last;
   end else begin : g_pipe_rd
      logic [RD_LAT-1:0] vld_q;
      logic [RD_LAT-1:0] lst_q;
      logic [IDX_W-1:0]  ix_q [RD_LAT];

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            vld_q <= '0;
            lst_q <= '0;
            for (int k = 0; k < RD_LAT; k++) ix_q[k] <= '0;
         end else begin
            vld_q[0] <= rd_en_o;
            lst_q[0] <= issue_last;
            ix_q[0]  <= rd_idx_o;
            for (int k = 1; k < RD_LAT; k++) begin
               vld_q[k] <= vld_q[k-1];
               lst_q[k] <= lst_q[k-1];
               ix_q[k]  <= ix_q[k-1];
            end
         end
      end

      assign ret_valid_o = vld_q[RD_LAT-1];
      assign ret_last_o  = lst_q[RD_LAT-1];
      assign ret_idx_o   = ix_q[RD_LAT-1];
   end
endmodule

// File: rtl/ale_srch_engine.sv
module ale_srch_engine
   import ale_srch_pkg::*;
#(
   parameter int unsigned  DEPTH   = 16,
   parameter int unsigned  ENTRY_W = 64,
   parameter int unsigned  RD_LAT  = 1,
   localparam int unsigned IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               start_i,
   input  logic               vlan_only_i,
   input  logic [47:0]        mac_i,
   input  logic [11:0]        vid_i,
   input  logic               use_vid_i,
   output logic               busy_o,
   output logic               tbl_rd_en_o,
   output logic [IDX_W-1:0]   tbl_rd_idx_o,
   input  logic [ENTRY_W-1:0] tbl_rd_data_i,
   output logic               done_o,
   output logic [1:0]         tier_o,
   output logic [IDX_W-1:0]   idx_o,
   output logic               full_o
);
   // Elaboration-time parameter checks
   if (DEPTH < 2) begin : g_chk_depth
      $error("ale_srch_engine: DEPTH must be at least 2");
   end
   if (ENTRY_W < ENTRY_BITS) begin : g_chk_width
      $error("ale_srch_engine: ENTRY_W too small for the entry layout");
   end
   if (RD_LAT > 4) begin : g_chk_lat
      $error("ale_srch_engine: RD_LAT above 4 not supported");
   end

   logic             accept;
   logic             ret_valid;
   logic             ret_last;
   logic [IDX_W-1:0] ret_idx;

   // Request captured at accept so inputs may change during the scan
   logic             req_vlan_only_q;
   logic [MAC_W-1:0] req_mac_q;
   logic [VID_W-1:0] req_vid_q;
   logic             req_use_vid_q;

   logic [NUM_TIERS-1:0] hit;
   logic [NUM_TIERS-1:0] found;
   logic [IDX_W-1:0]     cand_idx [NUM_TIERS];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         req_vlan_only_q <= 1'b0;
         req_mac_q       <= '0;
         req_vid_q       <= '0;
         req_use_vid_q   <= 1'b0;
      end else if (accept) begin
         req_vlan_only_q <= vlan_only_i;
         req_mac_q       <= mac_i;
         req_vid_q       <= vid_i;
         req_use_vid_q   <= use_vid_i;
      end
   end

   ale_srch_seq #(
      .DEPTH  (DEPTH),
      .RD_LAT (RD_LAT),
      .IDX_W  (IDX_W)
   ) u_seq (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .start_i     (start_i),
      .busy_o      (busy_o),
      .accept_o    (accept),
      .rd_en_o     (tbl_rd_en_o),
      .rd_idx_o    (tbl_rd_idx_o),
      .ret_valid_o (ret_valid),
      .ret_idx_o   (ret_idx),
      .ret_last_o  (ret_last),
      .done_o      (done_o)
   );

   ale_srch_classify #(
      .ENTRY_W (ENTRY_W)
   ) u_cls (
      .entry_i     (tbl_rd_data_i),
      .vlan_only_i (req_vlan_only_q),
      .mac_i       (req_mac_q),
      .vid_i       (req_vid_q),
      .use_vid_i   (req_use_vid_q),
      .hit_o       (hit)
   );

   for (genvar t = 0; t < NUM_TIERS; t++) begin : g_tier
      ale_srch_first #(
         .IDX_W (IDX_W)
      ) u_first (
         .clk_i   (clk_i),
         .rst_ni  (rst_ni),
         .clear_i (accept),
         .valid_i (ret_valid),
         .hit_i   (hit[t]),
         .idx_i   (ret_idx),
         .found_o (found[t]),
         .idx_o   (cand_idx[t])
      );
   end

   // Tier priority: match, then free, then evictable
   always_comb begin
      tier_o = TIER_NONE;
      idx_o  = '0;
      for (int t = NUM_TIERS - 1; t >= 0; t--) begin
         if (found[t]) begin
            tier_o = 2'(t);
            idx_o  = cand_idx[t];
         end
      end
   end

   assign full_o = (tier_o == TIER_NONE);

   logic unused_last;
   assign unused_last = ret_last;
endmodule

// File: rtl/ale_srch_chk.sv
module ale_srch_chk #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned IDX_W = 4
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             start_i,
   input logic             busy_o,
   input logic             tbl_rd_en_o,
   input logic [IDX_W-1:0] tbl_rd_idx_o,
   input logic             done_o,
   input logic [1:0]       tier_o,
   input logic [IDX_W-1:0] idx_o,
   input logic             full_o
);
   AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o); // R2

   AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> !busy_o); // R2

   AST_FIRST_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(busy_o) |-> (tbl_rd_en_o && tbl_rd_idx_o == '0)); // R2

   AST_READ_ASCEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tbl_rd_en_o && $past(tbl_rd_en_o))
         |-> (tbl_rd_idx_o == IDX_W'($past(tbl_rd_idx_o) + 1'b1))); // R2

   AST_READ_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tbl_rd_en_o |-> ({1'b0, tbl_rd_idx_o} < (IDX_W+1)'(DEPTH))); // R2

   AST_IDLE_NO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_o |-> !tbl_rd_en_o); // R10

   AST_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && !full_o) |-> ({1'b0, idx_o} < (IDX_W+1)'(DEPTH))); // R5

   AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!busy_o && !$past(busy_o))
         |-> ($stable(idx_o) && $stable(tier_o) && $stable(full_o))); // R11

   logic unused_start;
   assign unused_start = start_i;
endmodule

bind ale_srch_engine ale_srch_chk #(
   .DEPTH (DEPTH),
   .IDX_W (IDX_W)
) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .start_i      (start_i),
   .busy_o       (busy_o),
   .tbl_rd_en_o  (tbl_rd_en_o),
   .tbl_rd_idx_o (tbl_rd_idx_o),
   .done_o       (done_o),
   .tier_o       (tier_o),
   .idx_o        (idx_o),
   .full_o       (full_o)
);

// File: tb/test_ale_srch_engine.sv
module test_ale_srch_engine;
   localparam int DEPTH   = 16;
   localparam int ENTRY_W = 64;
   localparam int RD_LAT  = 1;
   localparam int IDX_W   = 4;
   localparam logic [47:0] MAC_A = 48'h02_11_22_33_44_55;
   localparam logic [47:0] MAC_B = 48'h06_aa_bb_cc_dd_ee;
   localparam logic [47:0] MC    = 48'h01_00_00_00_00_00;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic               rst_n, start, vlan_only, use_vid;
   logic [47:0]        mac;
   logic [11:0]        vid;
   logic               busy, rd_en, done, full;
   logic [IDX_W-1:0]   rd_idx, idx;
   logic [ENTRY_W-1:0] rdata;
   logic [1:0]         tier;

   logic [63:0] mem [DEPTH];

   int n_chk = 0;
   int n_fail = 0;
   int wd = 0;

   ale_srch_engine #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W), .RD_LAT(RD_LAT)) i_ale_srch_engine (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .vlan_only_i(vlan_only),
      .mac_i(mac), .vid_i(vid), .use_vid_i(use_vid), .busy_o(busy),
      .tbl_rd_en_o(rd_en), .tbl_rd_idx_o(rd_idx), .tbl_rd_data_i(rdata),
      .done_o(done), .tier_o(tier), .idx_o(idx), .full_o(full));

   // Table model with one registered read stage
   always @(posedge clk) if (rd_en) rdata <= mem[rd_idx];

   task automatic summary();
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   always @(posedge clk) begin
      wd++;
      if (wd == 150000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected < 150000", wd);
         summary();
         $finish;
      end
   end

   task automatic chk(string req, bit ok, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic [63:0] mk(logic [1:0] kind, logic [1:0] ty,
                                      logic [11:0] v, logic [47:0] m);
      return {kind, ty, v, m};
   endfunction

   // Expected result from the requirement text
   task automatic ref_search(bit vo, logic [47:0] m, logic [11:0] v, bit uv,
                             output int etier, output int eidx);
      int mi = -1, fi = -1, ai = -1;
      logic [11:0] cv = vo ? v : (uv ? v : 12'd0);
      for (int i = 0; i < DEPTH; i++) begin
         logic [1:0] ty = mem[i][61:60];
         logic [1:0] kd = mem[i][63:62];
         bit is_a = (ty == 2'd1) || (ty == 2'd3);
         bit mt = vo ? (ty == 2'd2 && mem[i][59:48] == cv)
                     : (is_a && mem[i][59:48] == cv && mem[i][47:0] == m);
         bit ag = is_a && !mem[i][40] && (kd == 2'd1 || kd == 2'd3);
         if (mt && mi < 0) mi = i;
         if (ty == 2'd0 && fi < 0) fi = i;
         if (ag && ai < 0) ai = i;
      end
      if (mi >= 0) begin etier = 0; eidx = mi; end
      else if (fi >= 0) begin etier = 1; eidx = fi; end
      else if (ai >= 0) begin etier = 2; eidx = ai; end
      else begin etier = 3; eidx = 0; end
   endtask

   task automatic run_search(string req, bit vo, logic [47:0] m, logic [11:0] v,
                             bit uv, bit poke);
      int etier, eidx, cyc, nrd;
      bit order_ok = 1'b1, extra = 1'b0, hold_ok = 1'b1;
      logic [IDX_W-1:0] h_idx;
      logic [1:0] h_tier;
      logic h_full;
      ref_search(vo, m, v, uv, etier, eidx);
      @(negedge clk);
      vlan_only = vo; mac = m; vid = v; use_vid = uv; start = 1'b1;
      @(negedge clk);
      start = 1'b0; cyc = 1; nrd = 0;
      forever begin
         if (rd_en) begin
            if (int'(rd_idx) != nrd) order_ok = 1'b0;
            nrd++;
         end
         if (done || cyc > 200) break;
         if (poke && cyc == 5) begin
            start = 1'b1; mac = ~m; vid = v + 12'd1; vlan_only = !vo; use_vid = !uv;
         end else start = 1'b0;
         @(negedge clk);
         cyc++;
      end
      start = 1'b0;
      chk("R2", cyc == DEPTH + RD_LAT + 1, "done latency", cyc, DEPTH + RD_LAT + 1);
      chk("R2", order_ok && nrd == DEPTH, "ascending reads", nrd, DEPTH);
      chk("R2", !busy, "busy in done cycle", busy, 0);
      chk(req, int'(tier) == etier, "tier", tier, etier);
      chk("R7", full == (etier == 3), "full flag", full, etier == 3);
      if (etier != 3) chk(req, int'(idx) == eidx, "index", idx, eidx);
      h_idx = idx; h_tier = tier; h_full = full;
      for (int k = 0; k < (poke ? DEPTH + 4 : 3); k++) begin
         @(negedge clk);
         mac = mac ^ 48'h1; vid = vid + 12'd3;
         if (k == 0) chk("R2", !done, "done pulse width", done, 0);
         if (k > 0 && done) extra = 1'b1;
         if (idx != h_idx || tier != h_tier || full != h_full) hold_ok = 1'b0;
      end
      chk("R11", hold_ok, "result hold", idx, h_idx);
      if (poke) chk("R10", !extra, "extra done", extra, 0);
   endtask

   task automatic fill_free();
      for (int i = 0; i < DEPTH; i++) mem[i] = mk(2'd0, 2'd0, 12'd0, 48'd0);
   endtask

   initial begin
      rst_n = 1'b0; start = 1'b0; vlan_only = 1'b0; use_vid = 1'b0;
      mac = '0; vid = '0;
      fill_free();
      repeat (3) @(negedge clk);
      chk("R1", !busy && !done && !rd_en, "reset outputs", {busy, done, rd_en}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", !busy && !done && !rd_en, "after reset", {busy, done, rd_en}, 0);

      // R5: empty table, lowest free slot
      run_search("R5", 1'b0, MAC_A, 12'd0, 1'b0, 1'b0);

      // R3, R9: match at 9 beats free at 2
      for (int i = 0; i < DEPTH; i++) mem[i] = mk(2'd0, 2'd1, 12'd0, MAC_B);
      mem[2] = mk(2'd0, 2'd0, 12'd0, 48'd0);
      mem[9] = mk(2'd0, 2'd1, 12'd0, MAC_A);
      run_search("R3", 1'b0, MAC_A, 12'd0, 1'b0, 1'b0);
      run_search("R9", 1'b0, MAC_A, 12'd77, 1'b0, 1'b0);

      // R3: tagged entry matches only with tag compare on; R4: tag forced to zero
      mem[9] = mk(2'd0, 2'd1, 12'd0, MAC_B);
      mem[6] = mk(2'd1, 2'd3, 12'd5, MAC_A);
      run_search("R3", 1'b0, MAC_A, 12'd5, 1'b1, 1'b0);
      run_search("R4", 1'b0, MAC_A, 12'd5, 1'b0, 1'b0);
      // R3: one octet different, no match
      run_search("R3", 1'b0, MAC_A ^ 48'h00_00_00_10_00_00, 12'd5, 1'b1, 1'b0);

      // R6, R9: no free; evictable at 3 and 7, persistent below
      for (int i = 0; i < DEPTH; i++) mem[i] = mk(2'd0, 2'd1, 12'd0, MAC_B);
      mem[1] = mk(2'd2, 2'd3, 12'd0, MAC_B);
      mem[3] = mk(2'd1, 2'd1, 12'd0, MAC_B);
      mem[7] = mk(2'd3, 2'd3, 12'd0, MAC_B);
      run_search("R6", 1'b0, MAC_A, 12'd0, 1'b0, 1'b0);
      mem[3] = mk(2'd1, 2'd1, 12'd0, MAC_B | MC);
      run_search("R6", 1'b0, MAC_A, 12'd0, 1'b0, 1'b0);

      // R7: nothing usable
      for (int i = 0; i < DEPTH; i++)
         case (i % 4)
            0: mem[i] = mk(2'd0, 2'd1, 12'd0, MAC_B);
            1: mem[i] = mk(2'd2, 2'd3, 12'd0, MAC_B);
            2: mem[i] = mk(2'd1, 2'd1, 12'd0, MAC_B | MC);
            default: mem[i] = mk(2'd3, 2'd2, 12'd9, MAC_B);
         endcase
      run_search("R7", 1'b0, MAC_A, 12'd0, 1'b0, 1'b0);

      // R8: VLAN-only search ignores address entries with the same tag
      fill_free();
      mem[4]  = mk(2'd0, 2'd3, 12'd7, MAC_A);
      mem[10] = mk(2'd0, 2'd2, 12'd7, 48'd0);
      mem[0]  = mk(2'd0, 2'd2, 12'd8, 48'd0);
      run_search("R8", 1'b1, MAC_A, 12'd7, 1'b0, 1'b0);
      run_search("R8", 1'b1, MAC_A, 12'd6, 1'b1, 1'b0);

      // R10: second start with other values during the scan
      run_search("R10", 1'b1, MAC_A, 12'd7, 1'b0, 1'b1);
      run_search("R10", 1'b0, MAC_A, 12'd7, 1'b1, 1'b1);

      // R9: sweep of table fills and request patterns
      for (int s = 0; s < 240; s++) begin
         for (int i = 0; i < DEPTH; i++) begin
            int h = (s * 73 + i * 29 + s * i * 13 + (s >> 2) * 7) & 32'hffff;
            logic [1:0] ty;
            logic [47:0] em;
            case (h % 7)
               0: ty = (s % 4 == 0) ? 2'd0 : 2'd2;
               1, 2: ty = 2'd1;
               3, 4: ty = 2'd3;
               default: ty = 2'd2;
            endcase
            em = ((h >> 6) & 1) != 0 ? MAC_A : MAC_B;
            if (((h >> 5) & 1) != 0) em = em | MC;
            mem[i] = mk(2'((h >> 3) & 3), ty, ((h >> 7) & 1) != 0 ? 12'd5 : 12'd0, em);
         end
         run_search("R9", (s % 5) == 4, (s % 3 == 0) ? (MAC_A | MC) : MAC_A,
                    (s % 2 == 0) ? 12'd5 : 12'd0, ((s >> 1) & 1) != 0, 1'b0);
      end

      summary();
      $finish;
   end
endmodule